// File: doc/BRIEF.md
# Debug Command Bus Access Engine

This block sits behind a serial debug front end and receives debug commands already assembled into bytes. A command starts with an opcode byte. The opcode is followed by a big-endian 16-bit address. Write commands then carry a big-endian 16-bit data word. After the last byte of a command, the engine waits for an idle cycle on the target's on-chip bus and uses that one cycle for a single byte or word access.

Read results are always 16 bits wide. Word accesses always use an even address. Byte accesses are steered to one lane by the parity of the address. If the bus gives no idle cycle within a bounded wait, the engine forces the access so that the host can count on a fixed latency. The host watches `busy_o`, and it collects read results from `rd_data_o` once `rd_ready_o` is high.

Top module: `dbg_bus_engine`

## Requirements
- R1: Opcodes are 8'hE0 read byte, 8'hE8 read word, 8'hC0 write byte and 8'hC8 write word. A read command is the opcode, the address high byte and the address low byte. A write command adds the data high byte and then the data low byte.
- R2: A byte in the opcode position that is not one of the four opcodes is discarded. After it, `busy_o` stays low, no bus request is made, and the next byte is treated as an opcode.
- R3: A word read drives `bus_addr_o` with bit 0 cleared and `bus_be_o`=2'b11. It then places the full `bus_rdata_i` word in `rd_data_o`, with `rd_ready_o` high, on the cycle after the access.
- R4: A byte read at an even address returns `{rdata[15:8],8'h00}` with `bus_be_o`=2'b10. At an odd address it returns `{8'h00,rdata[7:0]}` with `bus_be_o`=2'b01. The full address is driven on the bus.
- R5: A word write drives `bus_we_o`=1, `bus_be_o`=2'b11, the address with bit 0 cleared, and the whole data word on `bus_wdata_o`.
- R6: For a byte write at an even address, the engine drives data[15:8] on `bus_wdata_o[15:8]`. For a byte write at an odd address, it drives data[7:0] on `bus_wdata_o[7:0]`. The unused lane is zero, and `bus_be_o` is 2'b10 or 2'b01 respectively.
- R7: While waiting, the engine asserts `bus_req_o` for exactly one cycle. That cycle is the first one in which `bus_idle_i` is high.
- R8: If `bus_idle_i` stays low for MAX_WAIT (128) waiting cycles, the access is forced on the next cycle. The access therefore occurs within 150 cycles of the last command byte.
- R9: `busy_o` is high from the cycle after a valid opcode until the cycle after the bus access. Bytes that arrive while the engine waits for the bus are ignored.
- R10: `rd_ready_o` clears when the next valid opcode is accepted. `rd_data_o` changes only at read accesses.
- R11: After reset, `busy_o`, `rd_ready_o`, `bus_req_o` and `rd_data_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Command byte valid, one cycle per byte |
| rx_byte_i | input | 8 | Command byte |
| busy_o | output | 1 | Command in progress |
| rd_data_o | output | 16 | Latched read result |
| rd_ready_o | output | 1 | Read result valid |
| bus_req_o | output | 1 | Stolen bus cycle strobe |
| bus_we_o | output | 1 | Write access |
| bus_be_o | output | 2 | Byte lane enables, bit 1 = upper lane |
| bus_addr_o | output | 16 | Bus address |
| bus_wdata_o | output | 16 | Bus write data |
| bus_rdata_i | input | 16 | Bus read data, valid in the request cycle |
| bus_idle_i | input | 1 | Bus free this cycle |

## Verification
The assertions assume three things about the inputs. `bus_rdata_i` is valid combinationally in the cycle that `bus_req_o` is high. The bus accepts any strobe, including a forced one. The front end delivers at most one byte per cycle. The stimulus changes inputs only on falling edges and returns read data from a combinational memory model addressed by `bus_addr_o`. It raises `bus_idle_i` only once the engine is waiting, after a chosen delay, and some delays exceed the wait limit so that the forced path is exercised.

// File: rtl/dbg_bus_pkg.sv
package dbg_bus_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned LANES  = WORD_W / BYTE_W;

  typedef enum logic [7:0] {
    OP_RD_B = 8'hE0,
    OP_RD_W = 8'hE8,
    OP_WR_B = 8'hC0,
    OP_WR_W = 8'hC8
  } dbg_op_e;

  typedef enum logic [2:0] {
    ST_OP, ST_AH, ST_AL, ST_DH, ST_DL, ST_WAIT
  } cmd_st_e;

  typedef struct packed {
    logic              is_wr;
    logic              is_word;
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/cmd_collect.sv
module cmd_collect
  import dbg_bus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              done_i,
  output cmd_t              cmd_o,
  output logic              waiting_o,
  output logic              busy_o,
  output logic              op_accept_o
);
  cmd_st_e st_q;
  cmd_t    cmd_q;
  logic    op_known;

  always_comb begin
    unique case (rx_byte_i)
      OP_RD_B, OP_RD_W, OP_WR_B, OP_WR_W: op_known = 1'b1;
      default:                            op_known = 1'b0;
    endcase
  end

  assign op_accept_o = (st_q == ST_OP) && rx_valid_i && op_known;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_OP;
      cmd_q <= '0;
    end else begin
      unique case (st_q)
        ST_OP: if (op_accept_o) begin
          cmd_q.is_wr   <= (rx_byte_i == OP_WR_B) || (rx_byte_i == OP_WR_W);
          cmd_q.is_word <= (rx_byte_i == OP_RD_W) || (rx_byte_i == OP_WR_W);
          st_q          <= ST_AH;
        end
        ST_AH: if (rx_valid_i) begin
          cmd_q.addr[WORD_W-1:BYTE_W] <= rx_byte_i;
          st_q <= ST_AL;
        end
        ST_AL: if (rx_valid_i) begin
          cmd_q.addr[BYTE_W-1:0] <= rx_byte_i;
          st_q <= cmd_q.is_wr ? ST_DH : ST_WAIT;
        end
        ST_DH: if (rx_valid_i) begin
          cmd_q.data[WORD_W-1:BYTE_W] <= rx_byte_i;
          st_q <= ST_DL;
        end
        ST_DL: if (rx_valid_i) begin
          cmd_q.data[BYTE_W-1:0] <= rx_byte_i;
          st_q <= ST_WAIT;
        end
        ST_WAIT: if (done_i) st_q <= ST_OP;
        default: st_q <= ST_OP;
      endcase
    end
  end

  assign cmd_o     = cmd_q;
  assign waiting_o = (st_q == ST_WAIT);
  assign busy_o    = (st_q != ST_OP);

  // bytes arriving during the bus wait must not disturb the held command
  assert_wait_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && !done_i) |=> ($stable(cmd_q) && st_q == ST_WAIT));
  assert_unknown_op_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OP && rx_valid_i && !op_known) |=> (st_q == ST_OP));
endmodule

// File: rtl/steal_timer.sv
module steal_timer #(
  parameter int unsigned MAX_WAIT = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic idle_i,
  output logic fire_o
);
  localparam int unsigned CNT_W = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_WAIT);

  logic [CNT_W-1:0] cnt_q;
  logic             force_now;

  assign force_now = (cnt_q == CNT_MAX);
  assign fire_o    = active_i && (idle_i || force_now);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!active_i || fire_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  assert_wait_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  assert_force_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && force_now) |-> fire_o);
  assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (cnt_q == '0));
endmodule

// File: rtl/lane_steer.sv
module lane_steer
  import dbg_bus_pkg::*;
(
  input  cmd_t              cmd_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [WORD_W-1:0] addr_o,
  output logic [LANES-1:0]  be_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic [WORD_W-1:0] rdata_o
);
  // lane LANES-1 (upper) serves even byte addresses
  assign addr_o = cmd_i.is_word ? {cmd_i.addr[WORD_W-1:1], 1'b0} : cmd_i.addr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic PAR = (g == LANES - 1) ? 1'b0 : 1'b1;
    assign be_o[g] = cmd_i.is_word || (cmd_i.addr[0] == PAR);
    assign wdata_o[g*BYTE_W +: BYTE_W] = be_o[g] ? cmd_i.data[g*BYTE_W +: BYTE_W] : '0;
    assign rdata_o[g*BYTE_W +: BYTE_W] = be_o[g] ? rdata_i[g*BYTE_W +: BYTE_W] : '0;
  end

  always_comb begin
    assert_lane_sel_R4: assert (cmd_i.is_word ? (be_o == '1) : $onehot(be_o));
  end
endmodule

// File: rtl/dbg_bus_engine.sv
module dbg_bus_engine
  import dbg_bus_pkg::*;
#(
  parameter int unsigned MAX_WAIT = 128
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_byte_i,
  output logic        busy_o,
  output logic [15:0] rd_data_o,
  output logic        rd_ready_o,
  output logic        bus_req_o,
  output logic        bus_we_o,
  output logic [1:0]  bus_be_o,
  output logic [15:0] bus_addr_o,
  output logic [15:0] bus_wdata_o,
  input  logic [15:0] bus_rdata_i,
  input  logic        bus_idle_i
);
  cmd_t              cmd;
  logic              waiting, fire, op_accept;
  logic [WORD_W-1:0] rd_masked;

  cmd_collect u_collect (
    .clk_i, .rst_ni, .rx_valid_i, .rx_byte_i,
    .done_i      (fire),
    .cmd_o       (cmd),
    .waiting_o   (waiting),
    .busy_o      (busy_o),
    .op_accept_o (op_accept)
  );

  steal_timer #(.MAX_WAIT(MAX_WAIT)) u_timer (
    .clk_i, .rst_ni,
    .active_i (waiting),
    .idle_i   (bus_idle_i),
    .fire_o   (fire)
  );

  lane_steer u_lanes (
    .cmd_i   (cmd),
    .rdata_i (bus_rdata_i),
    .addr_o  (bus_addr_o),
    .be_o    (bus_be_o),
    .wdata_o (bus_wdata_o),
    .rdata_o (rd_masked)
  );

  assign bus_req_o = fire;
  assign bus_we_o  = cmd.is_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_ready_o <= 1'b0;
    end else if (fire && !cmd.is_wr) begin
      rd_data_o  <= rd_masked;
      rd_ready_o <= 1'b1;
    end else if (op_accept) begin
      rd_ready_o <= 1'b0;
    end
  end

  assert_req_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> busy_o);
  assert_done_free_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |=> !busy_o);
  assert_rd_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_we_o) |=> rd_ready_o);
  assert_rd_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_o && !bus_we_o) |=> $stable(rd_data_o));
  assert_word_even_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_be_o == 2'b11) |-> !bus_addr_o[0]);
  assert_no_idle_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bus_req_o);
endmodule

// File: tb/tb_dbg_bus_engine.sv
module tb_dbg_bus_engine;
  localparam int CLK_PERIOD = 10;
  localparam int MAXW = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        busy, rd_ready, bus_req, bus_we, bus_idle = 1'b0;
  logic [15:0] rd_data, bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_be;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: value depends on the even word address
  assign bus_rdata = {bus_addr[15:1], 1'b0} ^ 16'hC35A;

  dbg_bus_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .busy_o(busy), .rd_data_o(rd_data), .rd_ready_o(rd_ready),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_be_o(bus_be),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(bus_rdata), .bus_idle_i(bus_idle)
  );

  // {opcode, addr, data, idle delay}
  localparam int NV = 10;
  localparam logic [55:0] VEC [NV] = '{
    {8'hE8, 16'h1234, 16'h0000, 16'd0},
    {8'hE8, 16'h4321, 16'h0000, 16'd3},
    {8'hE0, 16'h0A10, 16'h0000, 16'd1},
    {8'hE0, 16'h0A11, 16'h0000, 16'd7},
    {8'hC8, 16'h2002, 16'hBEEF, 16'd0},
    {8'hC8, 16'h2003, 16'h1357, 16'd5},
    {8'hC0, 16'h3004, 16'hA55A, 16'd2},
    {8'hC0, 16'h3005, 16'h7E81, 16'd4},
    {8'hE8, 16'h00FE, 16'h0000, 16'd128},
    {8'hC0, 16'hFFFF, 16'h9966, 16'd300}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // wait for the stolen cycle; idle raised after dly cycles; returns cycle index
  task automatic wait_req(input int dly, output int k);
    k = -1;
    for (int i = 0; i < 400; i++) begin
      if (i == dly) bus_idle = 1'b1;
      #1;
      if (bus_req) begin k = i; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int k;
    logic [15:0] prev;
    @(negedge clk);
    #1;
    chk(!busy && !rd_ready && !bus_req && rd_data == 0, "R11 reset",
        {busy, rd_ready, bus_req, rd_data}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] op; logic [15:0] a, d, ea, ew, er; logic [1:0] eb; int dly, ek;
      bit wr, word;
      {op, a, d} = VEC[v][55:16];
      dly  = int'(VEC[v][15:0]);
      wr   = (op == 8'hC0) || (op == 8'hC8);
      word = (op == 8'hE8) || (op == 8'hC8);
      ea   = word ? {a[15:1], 1'b0} : a;
      eb   = word ? 2'b11 : (a[0] ? 2'b01 : 2'b10);
      ew   = word ? d : (a[0] ? {8'h00, d[7:0]} : {d[15:8], 8'h00});
      er   = ({ea[15:1], 1'b0} ^ 16'hC35A) & {{8{eb[1]}}, {8{eb[0]}}};
      ek   = (dly > MAXW) ? MAXW : dly;
      bus_idle = 1'b0;
      send(op);
      #1 chk(busy, "R9 busy after opcode", busy, 1);
      send(a[15:8]); send(a[7:0]);
      if (wr) begin send(d[15:8]); send(d[7:0]); end
      wait_req(dly, k);
      chk(k == ek, (dly > MAXW) ? "R8 forced access cycle" : "R7 idle access cycle", k, ek);
      chk(bus_addr == ea && bus_be == eb && bus_we == wr,
          word ? (wr ? "R5 word write addr/be" : "R3 word read addr/be")
               : (wr ? "R6 byte write addr/be" : "R4 byte read addr/be"),
          {bus_we, bus_be, bus_addr}, {wr, eb, ea});
      if (wr) chk(bus_wdata == ew, word ? "R5 word write data" : "R6 byte write lane data",
                  bus_wdata, ew);
      @(negedge clk);
      bus_idle = 1'b0;
      #1;
      chk(!busy && !bus_req, "R9 busy clears after access", {busy, bus_req}, 0);
      if (!wr) chk(rd_ready && rd_data == er, word ? "R3 word read result" : "R4 byte read result",
                   {rd_ready, rd_data}, {1'b1, er});
      @(negedge clk);
    end

    // R2: unknown opcode discarded, next byte is an opcode
    bus_idle = 1'b1;
    send(8'h55);
    #1 chk(!busy, "R2 unknown opcode ignored", busy, 0);
    for (int i = 0; i < 4; i++) begin
      #1 chk(!bus_req && !busy, "R2 no access after unknown opcode", {busy, bus_req}, 0);
      @(negedge clk);
    end
    bus_idle = 1'b0;

    // R1: command sequence, read word after discard, ready from prior write stays clear
    send(8'hE8); send(8'h40); send(8'h10);
    wait_req(2, k);
    chk(bus_addr == 16'h4010 && !bus_we, "R1 read byte order", bus_addr, 16'h4010);
    @(negedge clk); bus_idle = 1'b0;
    #1 prev = rd_data;
    chk(rd_ready && prev == (16'h4010 ^ 16'hC35A), "R1 read result", rd_data, 16'h4010 ^ 16'hC35A);

    // R10: new opcode clears ready, rd_data held through a write
    send(8'hC8);
    #1 chk(!rd_ready, "R10 ready clears on opcode", rd_ready, 0);
    chk(rd_data == prev, "R10 data held", rd_data, prev);
    send(8'h50); send(8'h00);
    // R9: bytes while waiting ignored (data phase first)
    send(8'h12); send(8'h34);
    send(8'hE0); send(8'h77); send(8'h66);
    chk(busy && !bus_req, "R9 still waiting", {busy, bus_req}, 2'b10);
    wait_req(1, k);
    chk(bus_we && bus_addr == 16'h5000 && bus_wdata == 16'h1234,
        "R9 bytes during wait ignored", bus_wdata, 16'h1234);
    @(negedge clk); bus_idle = 1'b0;
    #1 chk(!busy && !rd_ready && rd_data == prev, "R10 write leaves rd_data",
           {busy, rd_ready, rd_data}, {2'b00, prev});

    // R11: reset mid-command
    send(8'hE0);
    rst_n = 1'b0;
    #1 chk(!busy && !rd_ready && rd_data == 0, "R11 reset mid-command",
           {busy, rd_ready, rd_data}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule